// File: doc/BRIEF.md
# Quick-Sync Serial Pattern Checker

This block measures bit errors on a serial stream that carries a repeating user pattern of programmable length N. It needs no pre-loaded reference. After a burst opens, it skips a short settling window, stores the next N valid bits as its reference, and from then on compares each valid bit with the stored bit at the same position in the pattern. Two cumulative counters report how many bits were judged and how many of them were wrong.

Positions inside the pattern can be removed from measurement. A block mask hides a run of 32 consecutive positions. A bit mask hides every position whose index modulo 32 equals a chosen phase. The two masks can be used together. A masked position changes neither counter. The burst gate frames each burst of data, and every new burst starts a fresh synchronization. While locked, the checker counts the errors within each pattern period. If that count goes above a programmable limit, the checker drops lock and captures a new reference.

Top module: `qsync_checker`

## Requirements
- R1: While reset is asserted and after it is released, `locked` and `pat_start` are 0 and both counters are 0.
- R2: After `burst_gate` rises, the first SETTLE valid bits (default 4) are discarded. They are neither stored nor counted.
- R3: The next N valid bits, with N taken from `pat_len`, are stored as reference positions 0 to N-1 in arrival order. `locked` goes to 1 one cycle after the bit at position N-1 is stored.
- R4: While locked, each valid unmasked bit adds 1 to `bit_cnt`, and also adds 1 to `err_cnt` if it differs from the reference bit at its position. Outside lock neither counter changes. Both counters saturate at all ones.
- R5: `pat_start` is high for exactly one cycle, the cycle after a valid bit at position N-1 is accepted, either during capture or while locked.
- R6: With `blk_en` = 1, positions p with `blk_start` <= p < `blk_start`+32 are excluded from both counters.
- R7: With `bit_en` = 1, positions p with p mod 32 = `bit_phase` are excluded from both counters.
- R8: With both masks enabled, the excluded set is the union of the two sets.
- R9: A cycle with `din_vld` = 0 does not change the position, the reference, the state or the counters.
- R10: While `burst_gate` is 0, input bits are ignored and `locked` is 0 from the next cycle on. The next burst starts again from R2.
- R11: While locked, the counted errors at positions 0 to N-1 of one period are totalled. If the total exceeds `err_limit` when the bit at position N-1 is judged, `locked` falls in the next cycle, and the next valid bit is stored as the new reference position 0. A total equal to the limit keeps lock.
- R12: The counters keep their values across bursts and loss of lock. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | Qualifies `din` in this cycle |
| burst_gate | input | 1 | High while a burst is present |
| pat_len | input | 9 | Pattern length N (1 to MAX_LEN) |
| err_limit | input | 9 | Highest per-period error total that keeps lock |
| blk_en | input | 1 | Enable the 32-position block mask |
| blk_start | input | 9 | First position covered by the block mask |
| bit_en | input | 1 | Enable the one-in-32 bit mask |
| bit_phase | input | 5 | Position modulo 32 hidden by the bit mask |
| locked | output | 1 | Reference captured and comparison active |
| pat_start | output | 1 | One-cycle pulse after the last position of a period |
| err_cnt | output | 32 | Cumulative errors on counted bits |
| bit_cnt | output | 32 | Cumulative counted bits |

## Verification
The interesting cycle is the last position of a period in lock. On that one bit, the counters may increment, the start marker pulses, and the period error total may cross the limit, which drops lock and restarts capture. The bench provokes this by injecting three errors that end on position N-1 with a limit of two, and also a period with exactly two errors. A behavioural model judges every cycle: the final bit must still be counted, the marker must pulse, and lock must fall only when the total goes above the limit.

// File: rtl/qsync_checker.sv
module qsync_checker #(
  parameter int MAX_LEN = 256,
  parameter int SETTLE  = 4,
  parameter int CW      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         din,
  input  logic                         din_vld,
  input  logic                         burst_gate,
  input  logic [$clog2(MAX_LEN):0]     pat_len,
  input  logic [$clog2(MAX_LEN):0]     err_limit,
  input  logic                         blk_en,
  input  logic [$clog2(MAX_LEN):0]     blk_start,
  input  logic                         bit_en,
  input  logic [4:0]                   bit_phase,
  output logic                         locked,
  output logic                         pat_start,
  output logic [CW-1:0]                err_cnt,
  output logic [CW-1:0]                bit_cnt
);
  localparam int PW = $clog2(MAX_LEN);
  localparam int LW = PW + 1;
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  typedef enum logic [1:0] {ST_SETTLE, ST_CAPTURE, ST_CHECK} st_t;

  st_t            state;
  logic [SW-1:0]  settle_cnt;
  logic [PW-1:0]  pos;
  logic [LW-1:0]  len_q;
  logic [LW-1:0]  per_err;
  logic [MAX_LEN-1:0] ref_q;

  logic          last, in_blk, on_bit, masked, miss, hit;
  logic [LW:0]   p_ext, lo_ext;
  logic [LW-1:0] per_nxt;

  assign last    = ({1'b0, pos} == len_q - 1'b1);
  assign p_ext   = {2'b00, pos};
  assign lo_ext  = {1'b0, blk_start};
  assign in_blk  = blk_en && (p_ext >= lo_ext) && (p_ext < lo_ext + (LW+1)'(32));
  assign on_bit  = bit_en && (pos[4:0] == bit_phase);
  assign masked  = in_blk || on_bit;
  assign miss    = din ^ ref_q[pos];
  assign hit     = !masked && miss;
  assign per_nxt = per_err + {{PW{1'b0}}, hit};
  assign locked  = (state == ST_CHECK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_SETTLE;
      settle_cnt <= '0;
      pos        <= '0;
      len_q      <= LW'(1);
      per_err    <= '0;
      ref_q      <= '0;
      pat_start  <= 1'b0;
      err_cnt    <= '0;
      bit_cnt    <= '0;
    end else begin
      pat_start <= 1'b0;
      if (!burst_gate) begin
        state      <= ST_SETTLE;
        settle_cnt <= '0;
        pos        <= '0;
        per_err    <= '0;
      end else if (din_vld) begin
        case (state)
          ST_SETTLE: begin
            if (settle_cnt == SW'(SETTLE - 1)) begin
              state <= ST_CAPTURE;
              len_q <= pat_len;
              pos   <= '0;
            end else begin
              settle_cnt <= settle_cnt + 1'b1;
            end
          end
          ST_CAPTURE: begin
            ref_q[pos] <= din;
            if (last) begin
              pos       <= '0;
              state     <= ST_CHECK;
              pat_start <= 1'b1;
              per_err   <= '0;
            end else begin
              pos <= pos + 1'b1;
            end
          end
          ST_CHECK: begin
            if (!masked) begin
              if (bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;
              if (miss && err_cnt != CMAX) err_cnt <= err_cnt + 1'b1;
            end
            if (last) begin
              pos       <= '0;
              pat_start <= 1'b1;
              per_err   <= '0;
              if (per_nxt > err_limit) begin
                state <= ST_CAPTURE;
                len_q <= pat_len;
              end
            end else begin
              pos     <= pos + 1'b1;
              per_err <= per_nxt;
            end
          end
          default: state <= ST_SETTLE;
        endcase
      end
    end
  end

  a_r10_gate_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_gate |=> !locked);

  a_r5_lock_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> pat_start);

  a_r11_drop_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(burst_gate)) |-> pat_start);

  a_r4_err_le_bits: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= bit_cnt);

  a_r4_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> ($stable(bit_cnt) && $stable(err_cnt)));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bit_cnt == $past(bit_cnt) || bit_cnt == $past(bit_cnt) + 1'b1));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_gate && !din_vld) |=> ($stable(bit_cnt) && $stable(locked)));
endmodule

// File: tb/qsync_checker_test.sv
module qsync_checker_test;
  localparam int MAXL = 256;
  localparam int SETL = 4;

  logic clk = 1'b0;
  logic rst_n, din, din_vld, burst_gate, blk_en, bit_en;
  logic [8:0] pat_len, err_limit, blk_start;
  logic [4:0] bit_phase;
  logic locked, pat_start;
  logic [31:0] err_cnt, bit_cnt;

  always #10 clk = ~clk;

  qsync_checker #(.MAX_LEN(MAXL), .SETTLE(SETL), .CW(32)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .burst_gate(burst_gate),
    .pat_len(pat_len), .err_limit(err_limit), .blk_en(blk_en), .blk_start(blk_start),
    .bit_en(bit_en), .bit_phase(bit_phase), .locked(locked), .pat_start(pat_start),
    .err_cnt(err_cnt), .bit_cnt(bit_cnt));

  int nchk = 0, nfail = 0;
  string tag = "R1";

  int ms = 0, msc = 0, mpos = 0, mlen = 1, mper = 0, mbits = 0, merr = 0, mps = 0;
  bit mref [0:MAXL-1];
  bit pat [0:MAXL-1];
  int plen = 1, sidx = 0, ps_seen = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_masked(int p);
    bit a = blk_en && p >= int'(blk_start) && p < int'(blk_start) + 32;
    bit b = bit_en && (p % 32) == int'(bit_phase);
    return a || b;
  endfunction

  task automatic step(input bit b, input bit v, input bit g);
    din = b; din_vld = v; burst_gate = g;
    @(posedge clk);
    mps = 0;
    if (!g) begin
      ms = 0; msc = 0; mpos = 0; mper = 0;
    end else if (v) begin
      if (ms == 0) begin
        if (msc == SETL - 1) begin ms = 1; mlen = int'(pat_len); mpos = 0; end
        else msc++;
      end else if (ms == 1) begin
        mref[mpos] = b;
        if (mpos == mlen - 1) begin mpos = 0; ms = 2; mps = 1; mper = 0; end
        else mpos++;
      end else begin
        if (!is_masked(mpos)) begin
          mbits++;
          if (b != mref[mpos]) begin merr++; mper++; end
        end
        if (mpos == mlen - 1) begin
          mpos = 0; mps = 1;
          if (mper > int'(err_limit)) begin ms = 1; mlen = int'(pat_len); end
          mper = 0;
        end else mpos++;
      end
    end
    @(negedge clk);
    if (pat_start) ps_seen++;
    chk(locked == (ms == 2), tag, locked, ms == 2);
    chk(pat_start == mps[0], tag, pat_start, mps);
    chk(bit_cnt == 32'(mbits), tag, bit_cnt, mbits);
    chk(err_cnt == 32'(merr), tag, err_cnt, merr);
  endtask

  task automatic newpat(input int n, input int seed);
    plen = n; pat_len = 9'(n); sidx = 0;
    for (int i = 0; i < n; i++) pat[i] = ((i * i * 7 + i * 3 + seed) % 13) > 6;
  endtask

  task automatic stream(input int cnt, input int ef, input int et);
    for (int k = 0; k < cnt; k++) begin
      step(pat[sidx % plen] ^ (k >= ef && k <= et), 1'b1, 1'b1);
      sidx++;
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    int b0, e0, p0;
    rst_n = 0; din = 0; din_vld = 0; burst_gate = 0; blk_en = 0; bit_en = 0;
    pat_len = 9'd40; err_limit = 9'd100; blk_start = 0; bit_phase = 0;
    repeat (3) @(negedge clk);
    chk(!locked && !pat_start && err_cnt == 0 && bit_cnt == 0, "R1", locked, 0);
    rst_n = 1;
    step(0, 0, 0); step(1, 1, 0);
    chk(bit_cnt == 0 && !locked, "R1", bit_cnt, 0);

    tag = "R2"; newpat(40, 1);
    stream(SETL, 0, SETL - 1);
    tag = "R3";
    stream(40, -1, -1);
    chk(locked == 1, "R3", locked, 1);
    tag = "R4";
    stream(80, -1, -1);
    chk(bit_cnt == 80, "R4", bit_cnt, 80);
    chk(err_cnt == 0, "R2", err_cnt, 0);
    stream(40, 5, 7);
    chk(err_cnt == 3, "R4", err_cnt, 3);

    tag = "R9";
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0) step(~pat[sidx % plen], 1'b0, 1'b1);
      else begin step(pat[sidx % plen], 1'b1, 1'b1); sidx++; end
    end
    chk(bit_cnt == 160, "R9", bit_cnt, 160);

    tag = "R10";
    b0 = mbits;
    for (int i = 0; i < 5; i++) step(i[0], 1'b1, 1'b0);
    chk(!locked, "R10", locked, 0);
    chk(bit_cnt == 32'(b0), "R12", bit_cnt, b0);

    tag = "R6"; newpat(128, 5); err_limit = 9'd300; blk_en = 1; blk_start = 9'd64;
    stream(SETL, -1, -1);
    stream(128, -1, -1);
    chk(locked == 1, "R10", locked, 1);
    b0 = mbits; e0 = merr;
    stream(128, 0, 127);
    chk(mbits - b0 == 96 && bit_cnt == 32'(b0 + 96), "R6", int'(bit_cnt) - b0, 96);
    chk(err_cnt == 32'(e0 + 96), "R6", int'(err_cnt) - e0, 96);

    tag = "R7"; blk_en = 0; bit_en = 1; bit_phase = 5'd1;
    b0 = mbits;
    stream(128, 0, 127);
    chk(bit_cnt == 32'(b0 + 124), "R7", int'(bit_cnt) - b0, 124);

    tag = "R8"; blk_en = 1;
    b0 = mbits;
    stream(128, 0, 127);
    chk(bit_cnt == 32'(b0 + 93), "R8", int'(bit_cnt) - b0, 93);

    tag = "R5"; blk_en = 0; bit_en = 0;
    p0 = ps_seen;
    stream(256, -1, -1);
    chk(ps_seen - p0 == 2, "R5", ps_seen - p0, 2);

    tag = "R11"; err_limit = 9'd2;
    stream(128, 10, 11);
    chk(locked == 1, "R11", locked, 1);
    stream(128, 125, 127);
    chk(locked == 0, "R11", locked, 0);
    stream(128, -1, -1);
    chk(locked == 1, "R11", locked, 1);
    e0 = merr;
    stream(128, -1, -1);
    chk(err_cnt == 32'(e0), "R11", err_cnt, e0);

    tag = "R12";
    b0 = mbits;
    step(0, 1'b1, 1'b0);
    chk(bit_cnt == 32'(b0) && !locked, "R12", bit_cnt, b0);

    summary();
    $finish;
  end
endmodule